// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Comparator

This block is the digital reference path of a frequency synthesizer. An 11-bit down-counter divides the reference clock by a programmed ratio. It reloads itself from its own terminal count, and the resulting carry pulse is the reference event of a phase-frequency comparator. The other comparator event is the divided-VCO carry, which arrives as a single-cycle pulse synchronous to the same clock.

The comparator raises a pump-up request on each reference edge and a pump-down request on each VCO edge. Once both requests are high, it clears them together. Because of this, even a zero phase error gives a pair of one-cycle pulses, so the comparator has no dead zone. A control bit swaps the two requests to suit either loop-filter sense.

A lock indicator counts comparisons in which both requests rose in the same cycle. It asserts after four such comparisons in a row and drops on the first comparison that shows a lone pulse. A power-down input silences the pump requests, clears lock and holds the divider at its start value.

Top module: `refpfd_top`

## Requirements
- R1: With a ratio R in 3..2047, the reference carry repeats every R clock cycles. The first carry occurs in the cycle after the R-th rising edge following release of reset or power-down. A ratio written while running takes effect at the next reload.
- R2: A programmed ratio of 0, 1 or 2 divides by 3.
- R3: A reference carry sets the up request and a VCO pulse sets the down request, each one edge after the pulse. When one event leads the other by d cycles, the leading request stays high for d+1 cycles and the trailing request for 1 cycle.
- R4: When both requests are high they are both cleared at the next edge. Coincident events therefore produce an up pulse and a down pulse of exactly one cycle each.
- R5: With pol_inv = 1, pump_up carries the down request and pump_dn carries the up request. With pol_inv = 0 they carry their own requests.
- R6: lock_det rises at the edge following the fourth consecutive comparison in which both requests rose in the same cycle. With aligned events this is edge 4R+2 after release.
- R7: lock_det falls at the edge following the first cycle in which exactly one request is high.
- R8: While pwr_down is 1, pump_up, pump_dn and lock_det are 0 from the next edge on, and the divider is held at its start value. After release the divider restarts exactly as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the divider counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_pulse | input | 1 | Divided-VCO carry, one-cycle pulse |
| r_value | input | 11 | Reference division ratio |
| pol_inv | input | 1 | 1 swaps the up and down outputs |
| pwr_down | input | 1 | 1 silences outputs and holds the divider |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| lock_det | output | 1 | Lock indication |

## Verification
Each result is due at a known edge counted from release. The reference event occupies the cycle after edge mR, so a request rises at edge mR+1 or at edge mR+off+1 for a VCO pulse placed off cycles away. Lock is due at edge 4R+2 and a loss of lock at the edge after the first lone request; power-down takes effect one edge after it is applied. The bench numbers every edge after release and samples at the following falling edge. It records the edge at which each output first changes and compares that index, and the accumulated pulse widths, with values worked out from these counts.

// File: rtl/refpfd_pkg.sv
// Package: shared sizing constants for the reference divider and comparator.
// Assumes: ratios below RATIO_MIN are treated as RATIO_MIN by the divider.
package refpfd_pkg;
    localparam int RATIO_W    = 11;
    localparam int RATIO_MIN  = 3;
    localparam int LOCK_COUNT = 4;
endpackage

// File: rtl/ref_divider.sv
// Module: self-reloading reference down-counter.
// Emits a one-cycle carry every r_eff cycles, where r_eff is the ratio clamped
// to RATIO_MIN. The ratio is sampled only on reload. hold (power-down) keeps
// the counter at its start value, just like reset.
// Assumes: RATIO_MIN >= 2, so carries never occur on two cycles in a row.
module ref_divider #(
    parameter int RATIO_W   = refpfd_pkg::RATIO_W,
    parameter int RATIO_MIN = refpfd_pkg::RATIO_MIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [RATIO_W-1:0] ratio,
    output logic               carry
);
    localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(RATIO_MIN);

    logic [RATIO_W-1:0] ratio_eff;
    logic [RATIO_W-1:0] count_q;

    // Clamp the programmed ratio to the smallest legal value.
    always_comb begin
        ratio_eff = (ratio < MIN_V) ? MIN_V : ratio;
    end

    // Count down; on zero, reload from the ratio and emit the carry.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            count_q <= ratio_eff - 1'b1;
            carry   <= 1'b0;
        end else if (count_q == '0) begin
            count_q <= ratio_eff - 1'b1;
            carry   <= 1'b1;
        end else begin
            count_q <= count_q - 1'b1;
            carry   <= 1'b0;
        end
    end

    assert_carry_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);
    assert_reload_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !hold) |=> carry);
    assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !carry);
endmodule

// File: rtl/pfd_core.sv
// Module: digital phase-frequency comparator.
// A rising reference pulse sets up_q and a rising VCO pulse sets dn_q. When both
// are high they are both cleared at the next edge, so coincident events still
// give one-cycle pulses (no dead zone).
// Assumes: reference pulses are at least 3 cycles apart.
module pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ref_evt,
    input  logic vco_evt,
    output logic up_q,
    output logic dn_q
);
    logic ref_d, vco_d;
    logic ref_rise, vco_rise;

    // Edge detect on both event inputs.
    always_comb begin
        ref_rise = ref_evt & ~ref_d;
        vco_rise = vco_evt & ~vco_d;
    end

    // Register the previous event levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            ref_d <= 1'b0;
            vco_d <= 1'b0;
        end else begin
            ref_d <= ref_evt;
            vco_d <= vco_evt;
        end
    end

    // Set requests on events; clear both once they overlap.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (up_q && dn_q) begin
            up_q <= ref_rise;
            dn_q <= vco_rise;
        end else begin
            up_q <= up_q | ref_rise;
            dn_q <= dn_q | vco_rise;
        end
    end

    assert_overlap_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q) |=> !(up_q && dn_q));
    assert_ref_sets_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !hold && !(up_q && dn_q)) |=> up_q);
    assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!up_q && !dn_q));
endmodule

// File: rtl/lock_monitor.sv
// Module: gated-pulse lock indicator.
// A comparison is clean when both requests rose in the same cycle. After
// LOCK_COUNT clean comparisons in a row the lock flag is set. Any cycle with a
// lone request clears the flag and the run length.
// Assumes: requests come from pfd_core, so an overlap lasts one cycle.
module lock_monitor #(
    parameter int LOCK_COUNT = refpfd_pkg::LOCK_COUNT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic up,
    input  logic dn,
    output logic locked
);
    localparam int CW = $clog2(LOCK_COUNT + 1);
    localparam logic [CW-1:0] FULL = CW'(LOCK_COUNT);

    logic          up_d, dn_d;
    logic          clean, lone;
    logic [CW-1:0] run_q;

    // Classify the current cycle.
    always_comb begin
        clean = up & dn & ~up_d & ~dn_d;
        lone  = up ^ dn;
    end

    // Remember the previous request levels.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            up_d <= 1'b0;
            dn_d <= 1'b0;
        end else begin
            up_d <= up;
            dn_d <= dn;
        end
    end

    // Count clean comparisons and derive the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (lone) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (clean) begin
            if (run_q != FULL) run_q <= run_q + 1'b1;
            if (run_q >= FULL - 1'b1) locked <= 1'b1;
        end
    end

    assert_lone_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up ^ dn) |=> !locked);
    assert_lock_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (run_q == FULL));
    assert_pd_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !locked);
endmodule

// File: rtl/refpfd_top.sv
// Module: reference divider, phase-frequency comparator and lock indicator.
// The divider carry is the reference event. pol_inv swaps the pump outputs.
// pwr_down acts on every stage like a reset.
// Assumes: vco_pulse is synchronous to clk.
module refpfd_top #(
    parameter int RATIO_W    = refpfd_pkg::RATIO_W,
    parameter int RATIO_MIN  = refpfd_pkg::RATIO_MIN,
    parameter int LOCK_COUNT = refpfd_pkg::LOCK_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vco_pulse,
    input  logic [RATIO_W-1:0] r_value,
    input  logic               pol_inv,
    input  logic               pwr_down,
    output logic               pump_up,
    output logic               pump_dn,
    output logic               lock_det
);
    logic ref_carry;
    logic up_req, dn_req;

    ref_divider #(.RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (pwr_down),
        .ratio (r_value),
        .carry (ref_carry)
    );

    pfd_core u_pfd (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (pwr_down),
        .ref_evt (ref_carry),
        .vco_evt (vco_pulse),
        .up_q    (up_req),
        .dn_q    (dn_req)
    );

    lock_monitor #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (pwr_down),
        .up     (up_req),
        .dn     (dn_req),
        .locked (lock_det)
    );

    // Route the requests according to the selected polarity.
    always_comb begin
        pump_up = pol_inv ? dn_req : up_req;
        pump_dn = pol_inv ? up_req : dn_req;
    end

    assert_pol_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up == pump_dn) || (pump_up == (pol_inv ? dn_req : up_req)));
endmodule

// File: tb/refpfd_top_tb.sv
module refpfd_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_pulse = 1'b0;
    logic [10:0] r_value = 11'd5;
    logic        pol_inv = 1'b0;
    logic        pwr_down = 1'b0;
    logic        pump_up, pump_dn, lock_det;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    refpfd_top u_dut (
        .clk(clk), .rst_n(rst_n), .vco_pulse(vco_pulse), .r_value(r_value),
        .pol_inv(pol_inv), .pwr_down(pwr_down),
        .pump_up(pump_up), .pump_dn(pump_dn), .lock_det(lock_det)
    );

    // Columns: ratio, offset early, offset late, switch period, pol, periods,
    //          expected first pump_up edge, expected lock at end
    localparam int NV = 8;
    localparam int VEC [NV][8] = '{
        '{5,    0,  0, 99, 0, 6, 6,    1},
        '{10,   2,  2, 99, 0, 5, 11,   0},
        '{10,  -3, -3, 99, 0, 5, 11,   0},
        '{7,    2,  2, 99, 1, 5, 10,   0},
        '{1,    0,  0, 99, 0, 6, 4,    1},
        '{12,   0,  1,  6, 0, 8, 13,   0},
        '{2047, 0,  0, 99, 0, 1, 2048, 0},
        '{9,   -1, -1, 99, 1, 5, 9,    0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int first_up, lock_rise, lock_fall, up_tot, dn_tot;

    // Release from reset (or power-down), then run for the given periods.
    task automatic run(input int r, input int oe, input int ol, input int sw,
                       input int pol, input int per, input bit via_pd);
        int re;
        re = (r < 3) ? 3 : r;
        r_value = 11'(r);
        pol_inv = pol[0];
        vco_pulse = 1'b0;
        if (via_pd) pwr_down = 1'b1; else rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pwr_down = 1'b0;
        first_up = -1; lock_rise = -1; lock_fall = -1; up_tot = 0; dn_tot = 0;
        for (int k = 1; k <= per * re + re - 1; k++) begin
            @(negedge clk);
            if (pump_up && first_up < 0) first_up = k;
            if (lock_det && lock_rise < 0) lock_rise = k;
            if (!lock_det && lock_rise >= 0 && lock_fall < 0) lock_fall = k;
            up_tot += int'(pump_up);
            dn_tot += int'(pump_dn);
            vco_pulse = 1'b0;
            for (int m = 1; m <= per; m++)
                if (k == m * re + ((m >= sw) ? ol : oe)) vco_pulse = 1'b1;
        end
        vco_pulse = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        check(!pump_up && !pump_dn && !lock_det, "R8 reset state", {pump_up, pump_dn, lock_det}, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            int re, eu, ed, o;
            run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 1'b0);
            re = (VEC[v][0] < 3) ? 3 : VEC[v][0];
            check(first_up == VEC[v][6], "R1 R2 R5 first pump_up edge", first_up, VEC[v][6]);
            eu = 0; ed = 0;
            for (int m = 1; m <= VEC[v][5]; m++) begin
                o = (m >= VEC[v][3]) ? VEC[v][2] : VEC[v][1];
                eu += (o > 0) ? o + 1 : 1;
                ed += (o < 0) ? 1 - o : 1;
            end
            if (VEC[v][4] != 0) begin o = eu; eu = ed; ed = o; end
            check(up_tot == eu, "R3 R4 R5 pump_up cycles", up_tot, eu);
            check(dn_tot == ed, "R3 R4 R5 pump_dn cycles", dn_tot, ed);
            check(int'(lock_det) == VEC[v][7], "R6 lock at end", int'(lock_det), VEC[v][7]);
            if (VEC[v][1] == 0 && VEC[v][5] >= 4)
                check(lock_rise == 4 * re + 2, "R6 lock rise edge", lock_rise, 4 * re + 2);
            if (VEC[v][3] <= VEC[v][5])
                check(lock_fall == VEC[v][3] * re + 2, "R7 lock fall edge", lock_fall, VEC[v][3] * re + 2);
        end

        // R8: lock, then power down while a VCO pulse arrives
        run(6, 0, 0, 99, 0, 5, 1'b0);
        check(lock_det == 1'b1, "R6 locked before power-down", int'(lock_det), 1);
        pwr_down = 1'b1;
        vco_pulse = 1'b1;
        @(negedge clk);
        vco_pulse = 1'b0;
        check(!lock_det, "R8 lock cleared", int'(lock_det), 0);
        @(negedge clk);
        check(!pump_up && !pump_dn, "R8 pumps silent", {pump_up, pump_dn}, 0);

        // R8: restart from power-down behaves as from reset
        run(8, 0, 0, 99, 0, 4, 1'b1);
        check(first_up == 9, "R8 restart first pump_up edge", first_up, 9);
        check(lock_rise == 34, "R8 R6 lock rise after restart", lock_rise, 34);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule